// File: doc/BRIEF.md
# Multi-lane streaming BN, ReLU and max-pool stage

This block sits behind a convolution array and takes one convolution result per lane per cycle, for every lane at once. Each lane's stream can be scaled and offset (batch normalisation in fixed point), clipped at zero (ReLU), and reduced by a 2×2 max pool with stride 2. No intermediate result goes back to external memory. The pooled values go into a per-lane bank that is split into two halves.

One half is filled while the other half is read out through a lane/address read port. A `swap` pulse exchanges the roles of the two halves and restarts the frame. Pixels arrive in row-major order. Rows are `cfg_width` columns wide, where `cfg_width` is even and at most `MAX_COLS`, and a frame has an even number of rows. A ready flag tells the consumer that at least one complete pooled row is sitting in the half being filled.

Top module: `pool_stream_unit`

## Requirements
- R1: After reset, `bank_ready` is 0 and `wr_half` is 0.
- R2: With `cfg_bn_en`=1, each lane value x becomes ((x·scale) arithmetically shifted right by `cfg_shift`) + bias. All operands are 16-bit two's complement. With `cfg_bn_en`=0, x passes through unchanged.
- R3: The normalised result saturates to the range 32767 down to −32768 and never wraps.
- R4: With `cfg_relu_en`=1, negative values become 0. With `cfg_relu_en`=0, negative values are kept.
- R5: Each stored value is the signed maximum of a 2×2 window taken after R2–R4. The windows start at even rows and even columns and do not overlap.
- R6: Pooled values of a frame are written to addresses 0, 1, 2, … of each lane's bank in row-major pooled order. A row holds `cfg_width`/2 of them.
- R7: `swap` toggles `wr_half`. The read port returns lane `rd_lane`, address `rd_addr` of the half not being written, one clock after the request. Writing the other half leaves that data unchanged.
- R8: `bank_ready` goes to 1 on the second clock edge after the last pixel of an odd input row is accepted. It stays at 1 until `swap`, which clears it.
- R9: A pixel presented with `in_valid` in the same cycle as `swap` is ignored. `swap` restarts the row, column and write-address counting.
- R10: Lanes are processed independently. Lane k's result depends only on bits [16k+15:16k] of `in_data`.
- R11: The row width is taken from `cfg_width`, so different widths give correspondingly sized pooled rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A pixel for every lane is present |
| in_data | input | LANES·16 | Lane k at bits [16k+15:16k], signed |
| cfg_bn_en | input | 1 | Enable scale/shift/offset |
| cfg_relu_en | input | 1 | Enable zero clipping |
| cfg_scale | input | 16 | Signed multiplier |
| cfg_shift | input | 4 | Arithmetic right shift after the multiply |
| cfg_bias | input | 16 | Signed offset |
| cfg_width | input | $clog2(MAX_COLS+1) | Input columns per row, even |
| swap | input | 1 | Exchange halves and restart the frame |
| rd_lane | input | $clog2(LANES) | Lane to read |
| rd_addr | input | $clog2(DEPTH) | Address to read |
| rd_data | output | 16 | Read data, one cycle after the request |
| bank_ready | output | 1 | A full pooled row is in the write half |
| wr_half | output | 1 | Half currently being written |

## Verification
The bench drives values large enough in both directions to push the normaliser past its limits. A design that wrapped instead of clamping would return small values of the wrong sign. It also checks that negative maxima survive when clipping is off. The read half is inspected while the other half is being filled: a design that wrote into the read half, or flipped halves on the wrong event, would return the newer frame's values. Every swap also carries a bogus pixel. A design that accepted it would shift every later window by one column, so nearly all pooled values would mismatch. The ready flag is sampled on the two cycles around the completion of the first pooled row, which catches a flag that rises one stage early or late.

// File: rtl/pool_pkg.sv
package pool_pkg;
  localparam int PX_W = 16;
  localparam int SH_W = 4;

  typedef logic signed [PX_W-1:0] px_t;

  localparam px_t PX_MAX = {1'b0, {(PX_W-1){1'b1}}};
  localparam px_t PX_MIN = {1'b1, {(PX_W-1){1'b0}}};

  typedef struct packed {
    logic              bn_en;
    logic              relu_en;
    px_t               scale;
    logic [SH_W-1:0]   shift;
    px_t               bias;
  } post_cfg_t;

  // Clamp a wide signed sum into the pixel range.
  function automatic px_t clamp_px(input logic signed [2*PX_W:0] v);
    logic signed [2*PX_W:0] hi;
    logic signed [2*PX_W:0] lo;
    hi = {{(PX_W+1){1'b0}}, PX_MAX};
    lo = {{(PX_W+1){1'b1}}, PX_MIN};
    if (v > hi)      return PX_MAX;
    else if (v < lo) return PX_MIN;
    else             return v[PX_W-1:0];
  endfunction

  // Fixed-point normalisation: (x*scale >>> shift) + bias, saturated.
  function automatic px_t norm_px(input px_t x, input px_t scale,
                                  input logic [SH_W-1:0] sh, input px_t bias);
    logic signed [2*PX_W-1:0] prod;
    logic signed [2*PX_W-1:0] shifted;
    logic signed [2*PX_W:0]   total;
    prod    = (2*PX_W)'(x) * (2*PX_W)'(scale);
    shifted = prod >>> sh;
    total   = {shifted[2*PX_W-1], shifted} + {{(PX_W+1){bias[PX_W-1]}}, bias};
    return clamp_px(total);
  endfunction

  function automatic px_t relu_px(input px_t v, input logic en);
    return (en && v[PX_W-1]) ? px_t'(0) : v;
  endfunction

  function automatic px_t max_px(input px_t a, input px_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/post_lane.sv
module post_lane
  import pool_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_fire,
  input  px_t       x,
  input  post_cfg_t cfg,
  output px_t       y
);
  px_t normed;
  px_t clipped;

  always_comb begin
    normed  = cfg.bn_en ? norm_px(x, cfg.scale, cfg.shift, cfg.bias) : x;
    clipped = relu_px(normed, cfg.relu_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       y <= '0;
    else if (in_fire) y <= clipped;
  end
endmodule

// File: rtl/pool_lane.sv
module pool_lane
  import pool_pkg::*;
#(
  parameter int MAX_COLS = 16,
  localparam int HALF = MAX_COLS / 2,
  localparam int HW   = $clog2(HALF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  input  logic          a_odd_col,
  input  logic          a_row_odd,
  input  logic [HW-1:0] a_slot,
  input  px_t           a_px,
  output px_t           pooled
);
  px_t line_q [HALF];
  px_t hold_q;

  // Left column of the current window is held until its right neighbour arrives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (a_valid && !a_odd_col) hold_q <= a_px;
  end

  // Even rows park the horizontal maximum for the odd row below.
  always_ff @(posedge clk) begin
    if (a_valid && a_odd_col && !a_row_odd)
      line_q[a_slot] <= max_px(hold_q, a_px);
  end

  assign pooled = max_px(line_q[a_slot], max_px(hold_q, a_px));
endmodule

// File: rtl/bank_pair.sv
module bank_pair
  import pool_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_half,
  input  logic [AW-1:0] wr_addr,
  input  px_t           wr_data,
  input  logic          rd_half,
  input  logic [AW-1:0] rd_addr,
  output px_t           rd_q
);
  px_t mem [2*DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_half, wr_addr}] <= wr_data;
    rd_q <= mem[{rd_half, rd_addr}];
  end
endmodule

// File: rtl/pool_stream_unit.sv
module pool_stream_unit
  import pool_pkg::*;
#(
  parameter int LANES    = 16,
  parameter int MAX_COLS = 16,
  parameter int MAX_ROWS = 8,
  localparam int COL_W = $clog2(MAX_COLS + 1),
  localparam int HW    = $clog2(MAX_COLS / 2),
  localparam int DEPTH = (MAX_COLS / 2) * (MAX_ROWS / 2),
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES*PX_W-1:0] in_data,
  input  logic                  cfg_bn_en,
  input  logic                  cfg_relu_en,
  input  logic [PX_W-1:0]       cfg_scale,
  input  logic [SH_W-1:0]       cfg_shift,
  input  logic [PX_W-1:0]       cfg_bias,
  input  logic [COL_W-1:0]      cfg_width,
  input  logic                  swap,
  input  logic [LW-1:0]         rd_lane,
  input  logic [AW-1:0]         rd_addr,
  output logic [PX_W-1:0]       rd_data,
  output logic                  bank_ready,
  output logic                  wr_half
);
  post_cfg_t cfg;
  assign cfg = '{bn_en: cfg_bn_en, relu_en: cfg_relu_en, scale: cfg_scale,
                 shift: cfg_shift, bias: cfg_bias};

  // Input position tracking
  logic             in_fire;
  logic             last_col;
  logic [COL_W-1:0] col_q;
  logic             row_odd_q;

  assign in_fire  = in_valid & ~swap;
  assign last_col = (col_q == cfg_width - COL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      row_odd_q <= 1'b0;
    end else if (swap) begin
      col_q     <= '0;
      row_odd_q <= 1'b0;
    end else if (in_fire) begin
      if (last_col) begin
        col_q     <= '0;
        row_odd_q <= ~row_odd_q;
      end else begin
        col_q <= col_q + COL_W'(1);
      end
    end
  end

  // Stage A control, aligned with the post_lane registers
  logic          a_valid_q;
  logic [HW:0]   a_col_q;
  logic          a_row_odd_q;
  logic          a_last_q;
  logic          a_relu_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid_q   <= 1'b0;
      a_col_q     <= '0;
      a_row_odd_q <= 1'b0;
      a_last_q    <= 1'b0;
      a_relu_q    <= 1'b0;
    end else begin
      a_valid_q   <= in_fire;
      a_col_q     <= col_q[HW:0];
      a_row_odd_q <= row_odd_q;
      a_last_q    <= last_col;
      a_relu_q    <= cfg_relu_en;
    end
  end

  // Named events for the checker
  logic pool_fire;
  logic row_end_fire;
  assign pool_fire    = a_valid_q & a_col_q[0] & a_row_odd_q;
  assign row_end_fire = pool_fire & a_last_q;

  // Write address, half select and ready flag
  logic [AW-1:0] wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      wr_half    <= 1'b0;
      bank_ready <= 1'b0;
    end else if (swap) begin
      wr_ptr     <= '0;
      wr_half    <= ~wr_half;
      bank_ready <= 1'b0;
    end else begin
      if (pool_fire)    wr_ptr     <= wr_ptr + AW'(1);
      if (row_end_fire) bank_ready <= 1'b1;
    end
  end

  // Per-lane datapath
  px_t              lane_q [LANES];
  px_t              pooled [LANES];
  logic [LANES-1:0] pool_sign;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    px_t a_px;

    post_lane u_post (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_fire (in_fire),
      .x       (in_data[g*PX_W +: PX_W]),
      .cfg     (cfg),
      .y       (a_px)
    );

    pool_lane #(.MAX_COLS(MAX_COLS)) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_valid   (a_valid_q),
      .a_odd_col (a_col_q[0]),
      .a_row_odd (a_row_odd_q),
      .a_slot    (a_col_q[HW:1]),
      .a_px      (a_px),
      .pooled    (pooled[g])
    );

    assign pool_sign[g] = pooled[g][PX_W-1];

    bank_pair #(.DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .wr_en   (pool_fire),
      .wr_half (wr_half),
      .wr_addr (wr_ptr),
      .wr_data (pooled[g]),
      .rd_half (~wr_half),
      .rd_addr (rd_addr),
      .rd_q    (lane_q[g])
    );
  end

  logic [LW-1:0] rd_lane_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_lane_q <= '0;
    else        rd_lane_q <= rd_lane;
  end

  assign rd_data = lane_q[rd_lane_q];
endmodule

// File: rtl/pool_stream_unit_chk.sv
module pool_stream_unit_chk #(
  parameter int AW    = 5,
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             swap,
  input logic             wr_half,
  input logic             bank_ready,
  input logic             pool_fire,
  input logic             row_end_fire,
  input logic [AW-1:0]    wr_ptr,
  input logic [LANES-1:0] pool_sign,
  input logic             a_relu_q
);
  p_swap_flips_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> wr_half != $past(wr_half));

  p_swap_clears_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> !bank_ready);

  p_row_end_sets_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end_fire && !swap) |=> bank_ready);

  p_ready_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bank_ready) |-> $past(row_end_fire));

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_fire && !swap) |=> wr_ptr == $past(wr_ptr) + AW'(1));

  p_addr_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> wr_ptr == '0);

  p_relu_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_fire && a_relu_q) |-> pool_sign == '0);
endmodule

bind pool_stream_unit pool_stream_unit_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .swap         (swap),
  .wr_half      (wr_half),
  .bank_ready   (bank_ready),
  .pool_fire    (pool_fire),
  .row_end_fire (row_end_fire),
  .wr_ptr       (wr_ptr),
  .pool_sign    (pool_sign),
  .a_relu_q     (a_relu_q)
);

// File: tb/pool_stream_unit_tb.sv
module pool_stream_unit_tb;
  localparam int LANES    = 16;
  localparam int MAX_COLS = 16;
  localparam int MAX_ROWS = 8;
  localparam int COL_W    = $clog2(MAX_COLS + 1);
  localparam int DEPTH    = (MAX_COLS / 2) * (MAX_ROWS / 2);
  localparam int AW       = $clog2(DEPTH);
  localparam int LW       = $clog2(LANES);

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid = 1'b0;
  logic [LANES*16-1:0]   in_data = '0;
  logic                  cfg_bn_en = 1'b0;
  logic                  cfg_relu_en = 1'b0;
  logic [15:0]           cfg_scale = '0;
  logic [3:0]            cfg_shift = '0;
  logic [15:0]           cfg_bias = '0;
  logic [COL_W-1:0]      cfg_width = '0;
  logic                  swap = 1'b0;
  logic [LW-1:0]         rd_lane = '0;
  logic [AW-1:0]         rd_addr = '0;
  logic [15:0]           rd_data;
  logic                  bank_ready;
  logic                  wr_half;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit half_model = 0;
  int exp_q [LANES][DEPTH];
  int exp_cnt = 0;

  always #2 clk = ~clk;

  pool_stream_unit #(.LANES(LANES), .MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_bn_en(cfg_bn_en), .cfg_relu_en(cfg_relu_en), .cfg_scale(cfg_scale),
    .cfg_shift(cfg_shift), .cfg_bias(cfg_bias), .cfg_width(cfg_width),
    .swap(swap), .rd_lane(rd_lane), .rd_addr(rd_addr), .rd_data(rd_data),
    .bank_ready(bank_ready), .wr_half(wr_half)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int gen(int lane, int r, int c, int seed);
    int h;
    h = (lane * 131 + r * 29 + c * 7 + seed * 1009) * 40503;
    h = h ^ (h >>> 7);
    return int'(shortint'(h));
  endfunction

  // Independent model of the scale/offset/clip step, done in 64-bit arithmetic.
  function automatic int post_model(int x);
    longint p;
    if (cfg_bn_en) begin
      p = longint'(x) * longint'($signed(cfg_scale));
      p = p >>> cfg_shift;
      p = p + longint'($signed(cfg_bias));
      if (p > 32767)  p = 32767;
      if (p < -32768) p = -32768;
    end else begin
      p = x;
    end
    if (cfg_relu_en && p < 0) p = 0;
    return int'(p);
  endfunction

  task automatic build_expect(input int rows, input int width, input int seed);
    exp_cnt = (rows / 2) * (width / 2);
    for (int l = 0; l < LANES; l++) begin
      for (int pr = 0; pr < rows / 2; pr++) begin
        for (int pc = 0; pc < width / 2; pc++) begin
          int m;
          m = -100000;
          for (int dr = 0; dr < 2; dr++)
            for (int dc = 0; dc < 2; dc++) begin
              int v;
              v = post_model(gen(l, 2*pr + dr, 2*pc + dc, seed));
              if (v > m) m = v;
            end
          exp_q[l][pr * (width / 2) + pc] = m;
        end
      end
    end
  endtask

  task automatic set_cfg(input bit bn, input bit relu, input int scale,
                         input int sh, input int bias, input int width);
    @(negedge clk);
    cfg_bn_en   = bn;
    cfg_relu_en = relu;
    cfg_scale   = 16'(scale);
    cfg_shift   = 4'(sh);
    cfg_bias    = 16'(bias);
    cfg_width   = COL_W'(width);
  endtask

  task automatic stream_frame(input int rows, input int width, input int seed, input bit ready_chk);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < width; c++) begin
        @(negedge clk);
        in_valid = 1'b1;
        for (int l = 0; l < LANES; l++) in_data[l*16 +: 16] = 16'(gen(l, r, c, seed));
      end
    @(negedge clk);
    in_valid = 1'b0;
    if (ready_chk) check(bank_ready == 1'b0, "R8 ready low one cycle after last pixel", int'(bank_ready), 0);
    @(negedge clk);
    if (ready_chk) check(bank_ready == 1'b1, "R8 ready high two cycles after last pixel", int'(bank_ready), 1);
    repeat (2) @(negedge clk);
  endtask

  // Swap with a bogus pixel presented in the same cycle (R9).
  task automatic do_swap();
    @(negedge clk);
    swap     = 1'b1;
    in_valid = 1'b1;
    in_data  = {LANES{16'h7fff}};
    @(negedge clk);
    swap     = 1'b0;
    in_valid = 1'b0;
    half_model = ~half_model;
    check(wr_half == half_model, "R7 swap toggles write half", int'(wr_half), int'(half_model));
    check(bank_ready == 1'b0, "R8 swap clears ready", int'(bank_ready), 0);
  endtask

  task automatic read_one(input int l, input int a, input string tag);
    @(negedge clk);
    rd_lane = LW'(l);
    rd_addr = AW'(a);
    @(negedge clk);
    check(int'($signed(rd_data)) == exp_q[l][a], tag, int'($signed(rd_data)), exp_q[l][a]);
  endtask

  task automatic read_all(input string tag);
    for (int l = 0; l < LANES; l++)
      for (int a = 0; a < exp_cnt; a++) read_one(l, a, tag);
  endtask

  task automatic t_reset();
    check(bank_ready == 1'b0, "R1 ready low after reset", int'(bank_ready), 0);
    check(wr_half == 1'b0, "R1 write half zero after reset", int'(wr_half), 0);
  endtask

  task automatic t_plain_pool();
    set_cfg(1'b0, 1'b0, 0, 0, 0, 8);
    build_expect(2, 8, 1);
    stream_frame(2, 8, 1, 1'b1);
    do_swap();
    read_all("R5 R6 R10 plain max pool");
  endtask

  task automatic t_norm_relu();
    set_cfg(1'b1, 1'b1, 3, 1, -100, 16);
    stream_frame(4, 16, 2, 1'b0);
    // Previous frame must still be readable while the new one fills the other half.
    read_one(0, 0, "R7 read half kept during fill");
    read_one(5, 3, "R7 read half kept during fill");
    read_one(LANES - 1, exp_cnt - 1, "R7 read half kept during fill");
    build_expect(4, 16, 2);
    do_swap();
    read_all("R2 R4 R9 R11 normalise and clip");
  endtask

  task automatic t_saturate();
    set_cfg(1'b1, 1'b0, 32767, 0, 1000, 4);
    build_expect(2, 4, 3);
    stream_frame(2, 4, 3, 1'b0);
    do_swap();
    read_all("R3 R4 saturation, negatives kept");
  endtask

  task automatic t_clip_only();
    set_cfg(1'b0, 1'b1, 0, 0, 0, 8);
    build_expect(8, 8, 4);
    stream_frame(8, 8, 4, 1'b0);
    do_swap();
    read_all("R4 R6 R11 clip only, multi-row");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_pool();
    t_norm_relu();
    t_saturate();
    t_clip_only();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule